// File: doc/BRIEF.md
# FSK Tag Emulation Waveform Generator

This block produces the load-modulation sample stream that a 125 kHz proximity tag using frequency-shift keying sends back to a reader. A slow sample clock arrives from outside the core clock domain, and the block emits one new output level for each of its rising edges. A high output leaves the coil open and a low output shorts it. Each identifier bit is carried by two bursts, one at the carrier divided by eight and one at the carrier divided by ten. Their order gives the bit value.

A frame has four parts. It begins with a lone divide-by-eight cycle. Then comes a start marker of eight bursts that is deliberately not a valid bit pair. Then the identifier follows MSB first, with one lone divide-by-eight cycle in front of every group of four bits. After the last sample the frame starts again, and this continues for as long as the block is enabled. The identifier arrives in parallel and is captured at the first sample of each frame. A change made during a frame therefore appears only in the next frame.

Top module: `fsk_tag_gen`

## Requirements
- R1: While `enable` is low, including right after reset, `coilOpen` is 1 (coil open). It stays 1 on every sample-clock edge.
- R2: A divide-by-eight cycle is the eight samples 1,1,0,0,0,0,0,0 and a burst repeats it 6 times (48 samples). A divide-by-ten cycle is the ten samples 1,1,1,0,0,0,0,0,0,0 and a burst repeats it 5 times (50 samples).
- R3: Every frame opens with one lone divide-by-eight cycle (8 samples).
- R4: After the opening cycle, the start marker sends eight bursts in this order: ÷8, ÷8, ÷8, ÷10, ÷10, ÷10, ÷8, ÷10.
- R5: An identifier bit of value 1 is sent as a ÷10 burst and then a ÷8 burst. A bit of value 0 is sent as a ÷8 burst and then a ÷10 burst.
- R6: The identifier bits are sent MSB first, from bit 43 down to bit 0.
- R7: One lone 8-sample ÷8 cycle comes directly before each bit whose index modulo 4 is 3 (bits 43, 39, …, 3).
- R8: A frame is 4800 samples long. The sample after the last one of a frame is the first sample of the next frame.
- R9: `idIn` is captured at the first sample of each frame. A change during a frame does not alter that frame, and it is used from the next frame on.
- R10: `coilOpen` changes only on the core clock cycle after a synchronised rising edge of `sampleClkIn`. With no such edge, it holds its value.
- R11: Dropping `enable` in the middle of a frame abandons that frame. After `enable` is raised again, output restarts at the first sample of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; when low, the coil is held open |
| sampleClkIn | input | 1 | Asynchronous sample clock; each rising edge advances one sample |
| idIn | input | 44 | Identifier to transmit, captured at frame start |
| coilOpen | output | 1 | Modulation level: 1 opens the coil, 0 shorts it |

## Verification
The bench uses the default parameters: a 44-bit identifier, divide-by-8 and divide-by-10 cycles with 2 and 3 high samples, and burst repeat counts of 6 and 5. With these values the full 4800-sample frame is reachable, along with all eleven group separators, the wrap from the last bit into the next opening cycle, and a mid-frame identifier change followed by the next frame. The sample clock toggles every three core cycles, so each detected edge leaves margin before the next. Whole frames therefore fit comfortably in the run.

// File: rtl/fsk_tag_pkg.sv
package fsk_tag_pkg;

  // Start marker burst kinds, bit i is burst i (1 = divide-by-ten burst)
  localparam int MARK_LEN = 8;
  localparam logic [MARK_LEN-1:0] MARK_SEQ = 8'b1011_1000;
  localparam int MARK_FC10_CNT = $countones(MARK_SEQ);
  localparam int MARK_FC8_CNT = MARK_LEN - MARK_FC10_CNT;

  typedef enum logic [2:0] {
    PH_LEAD,
    PH_MARK,
    PH_SEP,
    PH_HALF0,
    PH_HALF1
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadId;
    logic level;
  } ctlT;

endpackage

// File: rtl/fsk_tag_dp.sv
module fsk_tag_dp
  import fsk_tag_pkg::*;
#(
  parameter int ID_W = 44,
  parameter int SYNC_STAGES = 2,
  localparam int BW = $clog2(ID_W)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            sampleClkIn,
  input  logic [ID_W-1:0] idIn,
  input  ctlT             ctl,
  input  logic [BW-1:0]   bitSel,
  output logic            sampleTick,
  output logic            curBit,
  output logic [ID_W-1:0] idHeld,
  output logic            coilOpen
);

  // Synchroniser chain plus one edge-detect flop
  logic [SYNC_STAGES:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= sampleClkIn;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= 1'b0;
      else       syncQ[g] <= syncQ[g-1];
    end
  end

  assign sampleTick = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  idHeld <= '0;
    else if (enable && sampleTick && ctl.loadId) idHeld <= idIn;
  end

  assign curBit = idHeld[bitSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           coilOpen <= 1'b1;
    else if (!enable)    coilOpen <= 1'b1;
    else if (sampleTick) coilOpen <= ctl.level;
  end

endmodule

// File: rtl/fsk_tag_ctrl.sv
module fsk_tag_ctrl
  import fsk_tag_pkg::*;
#(
  parameter int ID_W = 44,
  parameter int GROUP = 4,
  parameter int F8_LEN = 8,
  parameter int F8_HI = 2,
  parameter int F8_REP = 6,
  parameter int F10_LEN = 10,
  parameter int F10_HI = 3,
  parameter int F10_REP = 5,
  localparam int BW = $clog2(ID_W),
  localparam int MAX_LEN = (F8_LEN > F10_LEN) ? F8_LEN : F10_LEN,
  localparam int MAX_REP = (F8_REP > F10_REP) ? F8_REP : F10_REP,
  localparam int SW = $clog2(MAX_LEN),
  localparam int RW = $clog2(MAX_REP + 1),
  localparam int MW = $clog2(MARK_LEN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          sampleTick,
  input  logic          curBit,
  output ctlT           ctl,
  output logic [BW-1:0] bitSel
);

  phaseT phase;
  logic [SW-1:0] sampCnt;
  logic [RW-1:0] cycCnt;
  logic [MW-1:0] markIdx;
  logic [BW-1:0] bitIdx;

  logic kindFc10, endCyc, endBurst;
  int cycLen, hiLen, reps;

  function automatic logic sepBefore(input int idx);
    return (idx % GROUP) == (GROUP - 1);
  endfunction

  always_comb begin
    unique case (phase)
      PH_MARK:  kindFc10 = MARK_SEQ[markIdx];
      PH_HALF0: kindFc10 = curBit;
      PH_HALF1: kindFc10 = ~curBit;
      default:  kindFc10 = 1'b0;
    endcase
    cycLen = kindFc10 ? F10_LEN : F8_LEN;
    hiLen  = kindFc10 ? F10_HI : F8_HI;
    if (phase == PH_LEAD || phase == PH_SEP) reps = 1;
    else reps = kindFc10 ? F10_REP : F8_REP;
    endCyc   = int'(sampCnt) == cycLen - 1;
    endBurst = endCyc && (int'(cycCnt) == reps - 1);
  end

  assign ctl.level  = int'(sampCnt) < hiLen;
  assign ctl.loadId = (phase == PH_LEAD) && (sampCnt == '0);
  assign bitSel     = bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || !enable) begin
      phase   <= PH_LEAD;
      sampCnt <= '0;
      cycCnt  <= '0;
      markIdx <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      sampCnt <= endCyc ? '0 : sampCnt + 1'b1;
      if (endBurst)    cycCnt <= '0;
      else if (endCyc) cycCnt <= cycCnt + 1'b1;
      if (endBurst) begin
        unique case (phase)
          PH_LEAD: begin
            phase   <= PH_MARK;
            markIdx <= '0;
          end
          PH_MARK: begin
            if (int'(markIdx) == MARK_LEN - 1) begin
              bitIdx <= BW'(ID_W - 1);
              phase  <= sepBefore(ID_W - 1) ? PH_SEP : PH_HALF0;
            end else begin
              markIdx <= markIdx + 1'b1;
            end
          end
          PH_SEP:   phase <= PH_HALF0;
          PH_HALF0: phase <= PH_HALF1;
          default: begin
            if (bitIdx == '0) begin
              phase <= PH_LEAD;
            end else begin
              bitIdx <= bitIdx - 1'b1;
              phase  <= sepBefore(int'(bitIdx) - 1) ? PH_SEP : PH_HALF0;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/fsk_tag_gen.sv
module fsk_tag_gen
  import fsk_tag_pkg::*;
#(
  parameter int ID_W = 44,
  parameter int GROUP = 4,
  parameter int SYNC_STAGES = 2,
  parameter int F8_LEN = 8,
  parameter int F8_HI = 2,
  parameter int F8_REP = 6,
  parameter int F10_LEN = 10,
  parameter int F10_HI = 3,
  parameter int F10_REP = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            sampleClkIn,
  input  logic [ID_W-1:0] idIn,
  output logic            coilOpen
);

  localparam int BW = $clog2(ID_W);

  ctlT ctl;
  logic [BW-1:0] bitSel;
  logic sampleTick, curBit;
  logic [ID_W-1:0] idHeld;

  fsk_tag_ctrl #(
    .ID_W(ID_W), .GROUP(GROUP),
    .F8_LEN(F8_LEN), .F8_HI(F8_HI), .F8_REP(F8_REP),
    .F10_LEN(F10_LEN), .F10_HI(F10_HI), .F10_REP(F10_REP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleTick(sampleTick),
    .curBit(curBit), .ctl(ctl), .bitSel(bitSel)
  );

  fsk_tag_dp #(.ID_W(ID_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleClkIn(sampleClkIn),
    .idIn(idIn), .ctl(ctl), .bitSel(bitSel), .sampleTick(sampleTick),
    .curBit(curBit), .idHeld(idHeld), .coilOpen(coilOpen)
  );

endmodule

// File: rtl/fsk_tag_chk.sv
module fsk_tag_chk
  import fsk_tag_pkg::*;
#(
  parameter int ID_W = 44,
  parameter int GROUP = 4,
  parameter int F8_LEN = 8,
  parameter int F8_HI = 2,
  parameter int F8_REP = 6,
  parameter int F10_LEN = 10,
  parameter int F10_REP = 5
) (
  input logic            clk,
  input logic            rstN,
  input logic            enable,
  input logic            sampleTick,
  input logic            loadId,
  input logic            coilOpen,
  input logic [ID_W-1:0] idHeld
);

  localparam int BIT_LEN = F8_LEN * F8_REP + F10_LEN * F10_REP;
  localparam int FRAME_LEN = F8_LEN * (1 + ID_W / GROUP)
                           + MARK_FC8_CNT * F8_LEN * F8_REP
                           + MARK_FC10_CNT * F10_LEN * F10_REP
                           + ID_W * BIT_LEN;

  int cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= 0;
    else if (!enable)    cnt <= 0;
    else if (sampleTick) cnt <= (cnt == FRAME_LEN - 1) ? 0 : cnt + 1;
  end

  assert_open_when_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> coilOpen);

  assert_hold_no_edge_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sampleTick) |=> $stable(coilOpen));

  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sampleTick) |-> (loadId == (cnt == 0)));

  assert_lead_cycle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sampleTick && cnt < F8_LEN) |=> (coilOpen == $past(cnt < F8_HI)));

  assert_id_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && sampleTick && loadId) |=> $stable(idHeld));

endmodule

bind fsk_tag_gen fsk_tag_chk #(
  .ID_W(ID_W), .GROUP(GROUP), .F8_LEN(F8_LEN), .F8_HI(F8_HI), .F8_REP(F8_REP),
  .F10_LEN(F10_LEN), .F10_REP(F10_REP)
) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .sampleTick(sampleTick),
  .loadId(ctl.loadId), .coilOpen(coilOpen), .idHeld(idHeld)
);

// File: tb/tb_fsk_tag_gen.sv
module tb_fsk_tag_gen;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic sampleClkIn = 1'b0;
  logic [43:0] idIn = '0;
  logic coilOpen;

  always #4 clk = ~clk;

  fsk_tag_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .sampleClkIn(sampleClkIn), .idIn(idIn), .coilOpen(coilOpen)
  );

  int nChecks = 0;
  int nFail = 0;
  bit expQ[$];
  string tagQ[$];
  bit lastExp = 1'b1;
  event sampleDone;

  bit frameBits[$];
  string frameTags[$];

  // Monitor: pops one expected item per completed sample and compares it
  initial begin
    forever begin
      @(sampleDone);
      if (expQ.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL scoreboard: output sample with empty queue (actual %0b expected none)", coilOpen);
      end else begin
        automatic bit e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        nChecks++;
        if (coilOpen !== e) begin
          nFail++;
          $display("FAIL %s: coilOpen actual %0b expected %0b at %0t", t, coilOpen, e, $time);
        end
      end
    end
  end

  task automatic expect1(input bit e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    lastExp = e;
  endtask

  // One sample-clock period: 3 core cycles high, 3 low, then check
  task automatic pulse();
    @(negedge clk) sampleClkIn = 1'b1;
    repeat (3) @(negedge clk);
    sampleClkIn = 1'b0;
    repeat (3) @(negedge clk);
    -> sampleDone;
    #1;
  endtask

  task automatic addCyc(input int len, input int hi, input int reps, input string t);
    for (int r = 0; r < reps; r++)
      for (int s = 0; s < len; s++) begin
        frameBits.push_back(s < hi);
        frameTags.push_back(t);
      end
  endtask

  // Expected frame built from the requirement text
  task automatic buildFrame(input logic [43:0] id, input string pre);
    bit markKinds[8] = '{0, 0, 0, 1, 1, 1, 0, 1};
    frameBits.delete();
    frameTags.delete();
    addCyc(8, 2, 1, {pre, "R3 lead"});
    foreach (markKinds[k]) begin
      if (markKinds[k]) addCyc(10, 3, 5, {pre, "R4 R2 marker fc10"});
      else              addCyc(8, 2, 6, {pre, "R4 R2 marker fc8"});
    end
    for (int i = 43; i >= 0; i--) begin
      if (i % 4 == 3) addCyc(8, 2, 1, {pre, "R7 separator"});
      if (id[i]) begin
        addCyc(10, 3, 5, {pre, "R5 R6 bit1 first half"});
        addCyc(8, 2, 6, {pre, "R5 R6 bit1 second half"});
      end else begin
        addCyc(8, 2, 6, {pre, "R5 R6 bit0 first half"});
        addCyc(10, 3, 5, {pre, "R5 R6 bit0 second half"});
      end
    end
  endtask

  // Driver: runs up to nSamp samples of the frame, optionally changing idIn
  task automatic runFrame(input int nSamp, input int changeAt, input logic [43:0] newId);
    for (int k = 0; k < nSamp; k++) begin
      if (k == changeAt) idIn = newId;
      expect1(frameBits[k], frameTags[k]);
      pulse();
    end
  endtask

  task automatic directCheck(input bit cond, input string t, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    directCheck(coilOpen === 1'b1, "R1 reset state", coilOpen, 1);

    // R1: disabled, sample edges leave the coil open
    for (int k = 0; k < 5; k++) begin
      expect1(1'b1, "R1 disabled");
      pulse();
    end

    // Frame 1 with id A, idIn changed mid-frame to B (R9)
    idIn = 44'hA5_3C96_0F1E;
    buildFrame(44'hA5_3C96_0F1E, "");
    directCheck(frameBits.size() == 4800, "R8 frame length", frameBits.size(), 4800);
    @(negedge clk) enable = 1'b1;
    runFrame(4800, 2000, 44'h0FF_00AA_5571);

    // R10: no sample edge, output holds
    repeat (30) @(negedge clk);
    expect1(lastExp, "R10 hold without edge");
    -> sampleDone;
    #1;

    // Frame 2 directly follows (R8 wrap) and uses id B (R9)
    buildFrame(44'h0FF_00AA_5571, "R8 R9 ");
    runFrame(4800, -1, '0);

    // R11: abandon frame 3 part way
    buildFrame(44'h0FF_00AA_5571, "R11 partial ");
    runFrame(1234, -1, '0);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    directCheck(coilOpen === 1'b1, "R1 R11 open on disable", coilOpen, 1);
    idIn = 44'hFFF_FFFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      expect1(1'b1, "R11 disabled");
      pulse();
    end
    @(negedge clk) enable = 1'b1;
    buildFrame(44'hFFF_FFFF_FFFF, "R11 restart ");
    runFrame(4800, -1, '0);

    repeat (4) @(negedge clk);
    directCheck(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule